// File: doc/BRIEF.md
# Dual-Channel Successive-Approximation Converter Serial Master

This block drives a two-input, 12-bit successive-approximation analog-to-digital converter over a four-wire SPI-style link. A client asks for one conversion by pulsing a request together with an input selection and a wiring choice. The choice is either two single-ended inputs or one pseudo-differential pair with a chosen polarity. The master then pulls chip-select low and clocks a fixed frame of 17 serial-clock periods. During the first four periods it sends a command word. The converter spends the next periods sampling and converting. The master discards the leading null bit that the converter returns and then collects the 12 result bits, most significant first. At the end of the frame it raises chip-select, which also puts the converter into standby. It presents the straight-binary result for one cycle, tagged with the input selection that produced it.

The serial clock comes from a divider counted in system clocks. The half-period request is clamped at both ends. The upper clamp comes from the system clock rate and a floor on the serial clock (10 kHz by default), because the converter's hold capacitor droops at slower rates. The lower clamp is a parameter, set from the supply-dependent throughput ceiling (100 or 50 thousand samples per second at 18 serial clocks per sample). A single held request slot takes one request that arrives while a frame is running. After every frame, chip-select stays high for at least one full serial period.

Top module: `adc_spi_master`

## Requirements
- R1: While reset is applied and after it, before any request, cs_n is 1, busy is 0, rsp_valid is 0, mosi is 0 and sclk rests at its idle level.
- R2: The parameter SPI_MODE selects an idle clock level: 0 for SPI_MODE 0 and 1 for SPI_MODE 3. Whenever cs_n is 1, sclk is at that level. Each frame contains exactly 17 rising edges of sclk while cs_n is 0.
- R3: At rising sclk edges 1 to 4 of a frame, mosi carries, in order: a start bit of 1, the mode bit (1 = single-ended, i.e. req_diff = 0), the select bit equal to req_ch, and an order bit of 1 (most significant bit first).
- R4: The master samples miso at rising edges 6 to 17 and ignores the null bit at edge 5. It assembles the bits most significant first into rsp_data as straight binary (0 to 4095). rsp_valid is high for exactly one cycle, on the cycle in which cs_n returns to 1, and rsp_ch and rsp_diff then repeat the request's selection.
- R5: Every half period of sclk within a frame lasts max(MIN_HALF, min(div_half, MAX_HALF)) system clocks.
- R6: MAX_HALF equals SYS_HZ / (2 × MIN_SCK_HZ). A div_half above it never yields a slower serial clock.
- R7: busy is 1 from the cycle after a request is accepted until the chip-select gap ends. A request that arrives while busy is held and starts as soon as the master is idle. Only one request is held; any further request while the slot is full is dropped.
- R8: Between two frames, cs_n stays high for at least 2 × (half period) system clocks.
- R9: While cs_n is 0, mosi changes only when sclk falls or is low, never while sclk stays high.
- R10: The divider setting is captured when a frame starts. Changing div_half during a frame does not alter that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Conversion request pulse |
| req_ch | input | 1 | Input select, or pair polarity in differential mode |
| req_diff | input | 1 | 1 = pseudo-differential pair, 0 = single-ended |
| div_half | input | HALF_W | Requested serial half period in system clocks |
| busy | output | 1 | Frame or chip-select gap in progress |
| cs_n | output | 1 | Chip-select / shutdown, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Result data from the converter |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 12 | Straight-binary result |
| rsp_ch | output | 1 | Input select of the finished frame |
| rsp_diff | output | 1 | Mode of the finished frame |

## Verification
The hardest state to reach from the ports is the full held-request slot together with a third, dropped request, timed so that the held request starts straight out of the chip-select gap. The bench issues one request, then two more while busy is high. It changes the converter model's returned value during the gap, so that the second response can be traced to the held request, and it counts every response pulse to show that the third request produced none. The divider clamps are reached by sweeping div_half across and beyond both limits in a configuration with a small ceiling, while a bench monitor measures every sclk half period. Both clock polarities run side by side on identical stimulus.

// File: rtl/adc_spi_pkg.sv
// Package: shared constants and types for the converter serial master.
// Assumes a converter frame of command bits, one null bit, then result bits.
package adc_spi_pkg;

    localparam int RES_BITS  = 12;
    localparam int CMD_BITS  = 4;
    localparam int NULL_BITS = 1;
    localparam int FRAME_PER = CMD_BITS + NULL_BITS + RES_BITS;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic ch;
        logic diff;
    } adc_cmd_t;

endpackage

// File: rtl/adc_clk_div.sv
// Module: serial clock divider with range guard.
// Captures a clamped half-period on 'load' and pulses 'tick' once per
// half-period while 'run' is high. Assumes MIN_HALF >= 1 and MAX_HALF >=
// MIN_HALF, both representable in HALF_W bits.
module adc_clk_div #(
    parameter int HALF_W   = 16,
    parameter int MIN_HALF = 2,
    parameter int MAX_HALF = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HALF_W-1:0] div_req,
    input  logic              run,
    output logic              tick
);

    localparam logic [HALF_W-1:0] LO = HALF_W'(MIN_HALF);
    localparam logic [HALF_W-1:0] HI = HALF_W'(MAX_HALF);

    logic [HALF_W-1:0] eff_q;
    logic [HALF_W-1:0] dcnt_q;
    logic [HALF_W-1:0] clamped;

    // Clamp the requested half period into the legal window.
    always_comb begin
        if (div_req < LO)
            clamped = LO;
        else if (div_req > HI)
            clamped = HI;
        else
            clamped = div_req;
    end

    // Capture the clamped setting at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eff_q <= LO;
        else if (load)
            eff_q <= clamped;
    end

    assign tick = run && (dcnt_q == eff_q - 1'b1);

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || load)
            dcnt_q <= '0;
        else if (tick)
            dcnt_q <= '0;
        else
            dcnt_q <= dcnt_q + 1'b1;
    end

endmodule

// File: rtl/adc_req_slot.sv
// Module: one-deep holding slot for requests that arrive while busy.
// Offers either the held request or a fresh one to the sequencer; a
// request arriving while busy and the slot is full is dropped.
module adc_req_slot
    import adc_spi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  adc_cmd_t req_cmd,
    input  logic     busy,
    input  logic     take,
    output logic     start_valid,
    output adc_cmd_t start_cmd
);

    logic     pend_q;
    adc_cmd_t pend_cmd_q;

    assign start_valid = pend_q || (req_valid && !busy);
    assign start_cmd   = pend_q ? pend_cmd_q : req_cmd;

    // Hold a request that cannot start yet; release it when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_cmd_q <= '0;
        end else if (take && pend_q) begin
            pend_q     <= req_valid;
            pend_cmd_q <= req_cmd;
        end else if (req_valid && busy && !pend_q) begin
            pend_q     <= 1'b1;
            pend_cmd_q <= req_cmd;
        end
    end

endmodule

// File: rtl/adc_frame_seq.sv
// Module: converter frame sequencer.
// Walks a frame of FRAME_PER serial periods split into halves (low then
// high), drives the command on falling edges, samples result bits on
// rising edges after the null bit, then holds chip-select high for one
// full serial period. Assumes 'tick' marks half-period boundaries.
module adc_frame_seq
    import adc_spi_pkg::*;
#(
    parameter int SPI_MODE = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_valid,
    input  adc_cmd_t            start_cmd,
    input  logic                tick,
    output logic                take,
    output logic                run,
    output logic                busy,
    output logic                cs_n,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic                rsp_valid,
    output logic [RES_BITS-1:0] rsp_data,
    output logic                rsp_ch,
    output logic                rsp_diff
);

    localparam int   HALVES   = 2 * FRAME_PER;
    localparam int   HW       = $clog2(HALVES + 1);
    localparam int   PW       = HW - 1;
    localparam int   CW       = $clog2(CMD_BITS);
    localparam logic IDLE_LVL = (SPI_MODE == 3);
    localparam logic [HW-1:0] LAST_H   = HW'(HALVES - 1);
    localparam logic [PW-1:0] FIRST_DP = PW'(CMD_BITS + NULL_BITS);
    localparam logic [PW-1:0] CMD_END  = PW'(CMD_BITS);

    seq_state_t          state_q;
    logic [HW-1:0]       hcnt_q;
    logic [CMD_BITS-1:0] cmd_q;
    logic [RES_BITS-1:0] shreg_q;
    logic                gap_q;
    logic [HW-1:0]       hcnt_nx;
    logic [PW-1:0]       per_now;
    logic [PW-1:0]       per_nxt;

    assign take    = (state_q == ST_IDLE) && start_valid;
    assign run     = (state_q != ST_IDLE);
    assign busy    = run;
    assign hcnt_nx = hcnt_q + 1'b1;
    assign per_now = hcnt_q[HW-1:1];
    assign per_nxt = hcnt_nx[HW-1:1];

    // Frame state machine with serial pins and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            hcnt_q    <= '0;
            cmd_q     <= '0;
            shreg_q   <= '0;
            gap_q     <= 1'b0;
            cs_n      <= 1'b1;
            sclk      <= IDLE_LVL;
            mosi      <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_ch    <= 1'b0;
            rsp_diff  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        state_q  <= ST_RUN;
                        hcnt_q   <= '0;
                        cs_n     <= 1'b0;
                        sclk     <= 1'b0;
                        mosi     <= 1'b1;
                        cmd_q    <= {1'b1, start_cmd.ch, ~start_cmd.diff, 1'b1};
                        shreg_q  <= '0;
                        rsp_ch   <= start_cmd.ch;
                        rsp_diff <= start_cmd.diff;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (hcnt_q == LAST_H) begin
                            state_q   <= ST_GAP;
                            gap_q     <= 1'b0;
                            cs_n      <= 1'b1;
                            sclk      <= IDLE_LVL;
                            mosi      <= 1'b0;
                            rsp_valid <= 1'b1;
                            rsp_data  <= shreg_q;
                        end else begin
                            hcnt_q <= hcnt_nx;
                            sclk   <= ~hcnt_q[0];
                            if (!hcnt_q[0]) begin
                                if (per_now >= FIRST_DP)
                                    shreg_q <= {shreg_q[RES_BITS-2:0], miso};
                            end else if (per_nxt < CMD_END) begin
                                mosi <= cmd_q[per_nxt[CW-1:0]];
                            end else begin
                                mosi <= 1'b0;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_q)
                            state_q <= ST_IDLE;
                        else
                            gap_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_spi_master.sv
// Module: top of the converter serial master.
// Joins the request slot, divider and frame sequencer. MIN_HALF must be
// chosen from the throughput ceiling; the slow-clock ceiling is derived.
module adc_spi_master
    import adc_spi_pkg::*;
#(
    parameter int SPI_MODE    = 0,
    parameter int HALF_W      = 16,
    parameter int SYS_HZ      = 100_000_000,
    parameter int MIN_SCK_HZ  = 10_000,
    parameter int MIN_HALF    = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_ch,
    input  logic                req_diff,
    input  logic [HALF_W-1:0]   div_half,
    output logic                busy,
    output logic                cs_n,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic                rsp_valid,
    output logic [RES_BITS-1:0] rsp_data,
    output logic                rsp_ch,
    output logic                rsp_diff
);

    localparam int MAX_HALF = SYS_HZ / (2 * MIN_SCK_HZ);

    adc_cmd_t req_cmd;
    adc_cmd_t start_cmd;
    logic     start_valid;
    logic     take;
    logic     run;
    logic     tick;

    assign req_cmd.ch   = req_ch;
    assign req_cmd.diff = req_diff;

    adc_req_slot u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_cmd     (req_cmd),
        .busy        (busy),
        .take        (take),
        .start_valid (start_valid),
        .start_cmd   (start_cmd)
    );

    adc_clk_div #(
        .HALF_W   (HALF_W),
        .MIN_HALF (MIN_HALF),
        .MAX_HALF (MAX_HALF)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .div_req (div_half),
        .run     (run),
        .tick    (tick)
    );

    adc_frame_seq #(
        .SPI_MODE (SPI_MODE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (start_valid),
        .start_cmd   (start_cmd),
        .tick        (tick),
        .take        (take),
        .run         (run),
        .busy        (busy),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .mosi        (mosi),
        .miso        (miso),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_ch      (rsp_ch),
        .rsp_diff    (rsp_diff)
    );

endmodule

// File: rtl/adc_spi_master_chk.sv
// Module: protocol checker bound to the serial master.
// Watches the pins and strobes only; assumes reset is applied at start.
module adc_spi_master_chk #(
    parameter int SPI_MODE = 0,
    parameter int MIN_HALF = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic busy,
    input logic rsp_valid
);

    localparam logic IDLE_LVL = (SPI_MODE == 3);

    logic [15:0] hi_cnt;
    logic        had_frame;

    // Count cycles with chip-select high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_n)
            hi_cnt <= '0;
        else if (hi_cnt != 16'hFFFF)
            hi_cnt <= hi_cnt + 1'b1;
    end

    // Remember that at least one frame has ended since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            had_frame <= 1'b0;
        else if (rsp_valid)
            had_frame <= 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (cs_n && !busy && !rsp_valid));

    p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == IDLE_LVL));

    p_strobe_at_cs_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (cs_n && !$past(cs_n)));

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_covers_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    p_gap_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && had_frame) |-> (hi_cnt >= 16'(2 * MIN_HALF)));

    p_mosi_steady_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && sclk && $past(sclk)) |-> $stable(mosi));

endmodule

bind adc_spi_master adc_spi_master_chk #(
    .SPI_MODE (SPI_MODE),
    .MIN_HALF (MIN_HALF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .mosi      (mosi),
    .busy      (busy),
    .rsp_valid (rsp_valid)
);

// File: tb/test_adc_spi_master.sv
`timescale 1ns/1ps

// Behavioural converter: records the command, returns a null bit then
// the latched value most significant bit first on falling clock edges.
module adc_conv_model (
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        mosi,
    input  logic [11:0] seed,
    output logic        miso,
    output logic [3:0]  cmd,
    output int          rises
);
    logic [11:0] val;

    initial begin
        miso = 1'b0; cmd = '0; rises = 0; val = '0;
    end

    always @(negedge cs_n) begin
        val = seed; rises = 0; cmd = '0; miso = 1'b0;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (rises < 4) cmd[rises] = mosi;
            rises = rises + 1;
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (rises == 4) miso = 1'b0;
            else if (rises >= 5 && rises <= 16) miso = val[16 - rises];
        end
    end
endmodule

module test_adc_spi_master;
    localparam int MINH = 2;
    localparam int MAXH = 10;   // 200_000 / (2 * 10_000)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ch = 1'b0, req_diff = 1'b0;
    logic [15:0] div_half = 16'd2;
    logic [11:0] seed = '0;

    logic        busy0, cs0, sck0, mo0, mi0, rv0, rc0, rd0;
    logic        busy3, cs3, sck3, mo3, mi3, rv3, rc3, rd3;
    logic [11:0] data0, data3;
    logic [3:0]  cmd0, cmd3;
    int          rises0, rises3;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    adc_spi_master #(.SPI_MODE(0), .SYS_HZ(200_000), .MIN_SCK_HZ(10_000), .MIN_HALF(MINH))
    i_adc_spi_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ch(req_ch),
        .req_diff(req_diff), .div_half(div_half), .busy(busy0), .cs_n(cs0),
        .sclk(sck0), .mosi(mo0), .miso(mi0), .rsp_valid(rv0), .rsp_data(data0),
        .rsp_ch(rc0), .rsp_diff(rd0));

    adc_spi_master #(.SPI_MODE(3), .SYS_HZ(200_000), .MIN_SCK_HZ(10_000), .MIN_HALF(MINH))
    i_adc_spi_master_m3 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ch(req_ch),
        .req_diff(req_diff), .div_half(div_half), .busy(busy3), .cs_n(cs3),
        .sclk(sck3), .mosi(mo3), .miso(mi3), .rsp_valid(rv3), .rsp_data(data3),
        .rsp_ch(rc3), .rsp_diff(rd3));

    adc_conv_model m0 (.cs_n(cs0), .sclk(sck0), .mosi(mo0), .seed(seed),
                       .miso(mi0), .cmd(cmd0), .rises(rises0));
    adc_conv_model m3 (.cs_n(cs3), .sclk(sck3), .mosi(mo3), .seed(seed),
                       .miso(mi3), .cmd(cmd3), .rises(rises3));

    // Pin monitor on the mode-0 instance: half periods, gaps, mosi, strobes.
    int iv_min = 1 << 30, iv_max = 0, iv_cnt = 0;
    int hi_cnt = 0, last_gap = 0, mosi_bad = 0, rsp_cnt = 0;
    logic p_sck = 1'b0, p_cs = 1'b1, p_mo = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs0) begin
                iv_cnt = 0;
                hi_cnt = hi_cnt + 1;
            end else begin
                if (p_cs) begin last_gap = hi_cnt; hi_cnt = 0; end
                if (sck0 != p_sck) begin
                    if (iv_cnt < iv_min) iv_min = iv_cnt;
                    if (iv_cnt > iv_max) iv_max = iv_cnt;
                    iv_cnt = 1;
                end else begin
                    iv_cnt = iv_cnt + 1;
                end
                if (!p_cs && sck0 && p_sck && mo0 != p_mo) mosi_bad = mosi_bad + 1;
            end
            if (rv0) rsp_cnt = rsp_cnt + 1;
        end
        p_sck = sck0; p_cs = cs0; p_mo = mo0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp_half(input int d);
        if (d < MINH) return MINH;
        if (d > MAXH) return MAXH;
        return d;
    endfunction

    task automatic pulse_req(input logic ch, input logic df);
        @(negedge clk);
        req_valid = 1'b1; req_ch = ch; req_diff = df;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp();
        while (!rv0) @(negedge clk);
    endtask

    // Check one finished response against expectations.
    task automatic check_rsp(input logic ch, input logic df, input logic [11:0] v);
        logic [3:0] ecmd;
        ecmd = {1'b1, ch, ~df, 1'b1};
        chk(data0 == v, "R4 data mode0", int'(data0), int'(v));
        chk(data3 == v, "R4 data mode3", int'(data3), int'(v));
        chk(rv3 == 1'b1, "R4 strobe mode3", int'(rv3), 1);
        chk(rc0 == ch && rd0 == df, "R4 tag", int'({rc0, rd0}), int'({ch, df}));
        chk(cmd0 == ecmd, "R3 command mode0", int'(cmd0), int'(ecmd));
        chk(cmd3 == ecmd, "R3 command mode3", int'(cmd3), int'(ecmd));
        chk(rises0 == 17 && rises3 == 17, "R2 rising edges", rises0 * 100 + rises3, 1717);
        @(negedge clk);
        chk(!rv0 && !rv3, "R4 single-cycle strobe", int'(rv0), 0);
    endtask

    task automatic frame(input logic ch, input logic df, input logic [11:0] v, input int d);
        seed = v; div_half = 16'(d);
        iv_min = 1 << 30; iv_max = 0;
        pulse_req(ch, df);
        wait_rsp();
        check_rsp(ch, df, v);
        while (busy0) @(negedge clk);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet pins under reset
        chk(cs0 && cs3, "R1 cs_n in reset", int'({cs0, cs3}), 3);
        chk(!sck0 && sck3, "R1 idle clocks in reset", int'({sck0, sck3}), 1);
        chk(!busy0 && !rv0 && !mo0, "R1 busy/strobe/mosi in reset", int'({busy0, rv0, mo0}), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(cs0 && !busy0 && !rv0 && !busy3, "R1 idle after reset", int'({cs0, busy0, rv0}), 4);
        chk(!sck0 && sck3, "R2 idle levels", int'({sck0, sck3}), 1);

        // R3 R4: every selection against a set of result patterns
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 16; k++) begin
                logic [11:0] v;
                if (k < 12) v = 12'(1 << k);
                else if (k == 12) v = 12'h000;
                else if (k == 13) v = 12'hFFF;
                else if (k == 14) v = 12'hA5A;
                else v = 12'(k * 263 + c * 911);
                frame(c[0], c[1], v, MINH);
                chk(iv_min == MINH && iv_max == MINH, "R5 half period at minimum", iv_max, MINH);
            end
        end

        // R5 R6: divider sweep across both clamps
        for (int d = 0; d <= MAXH + 4; d++) begin
            frame(d[0], 1'b0, 12'(d * 301), d);
            chk(iv_min == clamp_half(d) && iv_max == clamp_half(d),
                "R5 R6 clamped half period", iv_max, clamp_half(d));
        end
        frame(1'b1, 1'b1, 12'h3C3, 16'hFFFF);
        chk(iv_max == MAXH, "R6 slow-clock guard", iv_max, MAXH);

        // R10: divider change mid-frame has no effect on that frame
        seed = 12'h123; div_half = 16'd3; iv_min = 1 << 30; iv_max = 0;
        pulse_req(1'b0, 1'b1);
        repeat (10) @(negedge clk);
        div_half = 16'd8;
        wait_rsp();
        check_rsp(1'b0, 1'b1, 12'h123);
        chk(iv_min == 3 && iv_max == 3, "R10 divider latched", iv_max, 3);
        while (busy0) @(negedge clk);

        // R7 R8: held request, dropped third request, gap length
        begin
            int base;
            base = rsp_cnt;
            seed = 12'h7E1; div_half = 16'd4;
            pulse_req(1'b1, 1'b0);
            chk(busy0, "R7 busy after accept", int'(busy0), 1);
            repeat (5) @(negedge clk);
            pulse_req(1'b0, 1'b1);
            pulse_req(1'b1, 1'b1);
            wait_rsp();
            check_rsp(1'b1, 1'b0, 12'h7E1);
            seed = 12'h0B4;
            chk(busy0, "R7 busy during gap", int'(busy0), 1);
            wait_rsp();
            check_rsp(1'b0, 1'b1, 12'h0B4);
            chk(last_gap >= 8, "R8 chip-select gap", last_gap, 8);
            repeat (300) @(negedge clk);
            chk(rsp_cnt - base == 2, "R7 third request dropped", rsp_cnt - base, 2);
            chk(!busy0 && cs0, "R7 idle after held request", int'({busy0, cs0}), 1);
        end

        chk(mosi_bad == 0, "R9 mosi steady while sclk high", mosi_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule